// File: doc/BRIEF.md
# Image Sensor Control Register Target (Two-Wire Serial)

This block is the control-port side of an image sensor. It answers on a two-wire serial bus at a fixed 7-bit device address and exposes a file of 16-bit configuration registers. A bus master first writes an 8-bit register pointer. It then moves whole registers as byte pairs, most significant byte first. The pointer steps to the next register after each complete pair, so one transaction can load or dump a run of neighbouring registers, such as a window origin followed by its size.

Some locations have side effects. Location 0x00 is a fixed, read-only identification word. Bit 0 of location 0x0D keeps the rest of the file at its defaults for as long as it is set. Bit 0 of location 0xF1 is the chip-enable bit, which appears on an output pin. The block samples SCL and SDA with its own system clock. It drives SDA only as an open-drain pull-down enable. No valid/ready stream appears at the block's edge: the serial bus paces every transfer, and the target always accepts what the master sends.

Top module: `sensor_ctl_target`

## Requirements
- R1: The target acknowledges the address byte 0xBA (device 0x5D, write) and 0xBB (read). Any other address byte gets no acknowledge, and the target ignores the rest of that transaction until the next start condition.
- R2: In a write, the first data byte after the address sets the register pointer. Each following pair of bytes is the high byte and then the low byte of the register at the pointer. The register is updated only when the low byte arrives.
- R3: The pointer advances by one after every complete register, in a write or in a read. It is 8 bits wide and wraps from 0xFF to 0x00.
- R4: A read is a pointer write, then a repeated start with address 0xBB. The target returns the high byte, then the low byte, of successive registers. A master acknowledge continues the read; a master non-acknowledge ends it.
- R5: Location 0x00 always reads 0x8431, and writes to it have no effect.
- R6: While bit 0 of location 0x0D is 1, every other writable location (0x01–0x0F and 0xF1) is held at 0x0000 and writes to them are ignored. Location 0x0D itself stays writable. Writing bit 0 back to 0 releases the file.
- R7: Bit 0 of location 0xF1 drives the `chip_en` output and reads back as written. Its other bits read 0. After reset, `chip_en` is 0 and location 0xF1 reads 0x0000.
- R8: Locations 0x10–0xFF other than 0xF1 read 0x0000, and writes to them are ignored. Locations 0x01–0x0F reset to 0x0000.
- R9: If a read starts after only the high byte of a register pair has been written, the read returns the complete stored 16-bit register value. The stray high byte is discarded and the register stays unchanged.
- R10: `sda_oe` is 0 after reset and at idle. It is asserted only in acknowledge slots and in read-data bit slots that carry a 0, and it changes only while the synchronised SCL is low. Both bus inputs pass through a two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| chip_en | output | 1 | Chip-enable bit from location 0xF1 |

## Verification
The assertions assume the bus is much slower than `clk`. Each SCL high or low phase lasts at least four system clocks, so the synchroniser and edge detector see every edge and `sda_oe` settles before the next SCL rise. They also assume a single master, and that SDA moves while SCL is high only to form a start or stop condition. The bench keeps within these limits. It holds every bus quarter-phase for five clocks, changes SDA only while SCL is low (except at start and stop conditions), and drives all inputs on the falling edge of `clk`.

// File: rtl/sensor_ctl_pkg.sv
package sensor_ctl_pkg;
  localparam logic [6:0]  DEV_ADDR  = 7'h5D;
  localparam logic [15:0] ID_VALUE  = 16'h8431;
  localparam logic [7:0]  ID_PTR    = 8'h00;
  localparam logic [7:0]  HOLD_PTR  = 8'h0D;
  localparam logic [7:0]  CEN_PTR   = 8'hF1;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_ADDR,
    BS_AACK,
    BS_WDATA,
    BS_WACK,
    BS_RDATA,
    BS_RACK
  } bus_state_t;
endpackage

// File: rtl/bus_in_sync.sv
module bus_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s
);
  logic [STAGES-1:0] scl_chain, sda_chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) begin
            scl_chain[0] <= 1'b1;
            sda_chain[0] <= 1'b1;
          end else begin
            scl_chain[0] <= scl_i;
            sda_chain[0] <= sda_i;
          end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) begin
            scl_chain[g] <= 1'b1;
            sda_chain[g] <= 1'b1;
          end else begin
            scl_chain[g] <= scl_chain[g-1];
            sda_chain[g] <= sda_chain[g-1];
          end
      end
    end
  endgenerate

  assign scl_s = scl_chain[STAGES-1];
  assign sda_s = sda_chain[STAGES-1];
endmodule

// File: rtl/bus_bit_engine.sv
module bus_bit_engine
  import sensor_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic       txn_start,
  output logic       rd_start,
  output logic       rd_next,
  output logic       wr_valid,
  output logic       wr_first,
  output logic [7:0] wr_byte
);
  bus_state_t st;
  logic       scl_q, sda_q;
  logic [3:0] bitcnt;
  logic [7:0] sh;
  logic       is_rd, mack;
  logic       start_c, stop_c, rise, fall;
  logic [7:0] in_byte;

  assign start_c = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise    = scl_s & ~scl_q;
  assign fall    = ~scl_s & scl_q;
  assign in_byte = {sh[6:0], sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= BS_IDLE; scl_q <= 1'b1; sda_q <= 1'b1; bitcnt <= '0; sh <= '0;
      is_rd <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0; txn_start <= 1'b0;
      rd_start <= 1'b0; rd_next <= 1'b0; wr_valid <= 1'b0; wr_first <= 1'b0;
      wr_byte <= '0;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      txn_start <= 1'b0; rd_start <= 1'b0; rd_next <= 1'b0; wr_valid <= 1'b0;
      if (start_c) begin
        st <= BS_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= BS_IDLE; sda_oe <= 1'b0;
      end else begin
        unique case (st)
          BS_IDLE: ;
          BS_ADDR: begin
            if (rise) begin
              sh <= in_byte;
              bitcnt <= bitcnt + 4'd1;
              if (bitcnt == 4'd7) begin
                if (in_byte[7:1] == DEV_ADDR) begin
                  txn_start <= 1'b1;
                  rd_start  <= in_byte[0];
                  is_rd     <= in_byte[0];
                end else begin
                  st <= BS_IDLE;
                end
              end
            end
            if (fall && bitcnt == 4'd8) begin
              st <= BS_AACK; sda_oe <= 1'b1;
            end
          end
          BS_AACK: if (fall) begin
            bitcnt <= '0;
            if (is_rd) begin
              st <= BS_RDATA; sh <= rd_byte; sda_oe <= ~rd_byte[7];
            end else begin
              st <= BS_WDATA; sda_oe <= 1'b0; wr_first <= 1'b1;
            end
          end
          BS_WDATA: begin
            if (rise) begin
              sh <= in_byte;
              bitcnt <= bitcnt + 4'd1;
              if (bitcnt == 4'd7) begin
                wr_valid <= 1'b1; wr_byte <= in_byte;
              end
            end
            if (fall && bitcnt == 4'd8) begin
              st <= BS_WACK; sda_oe <= 1'b1;
            end
          end
          BS_WACK: if (fall) begin
            st <= BS_WDATA; sda_oe <= 1'b0; bitcnt <= '0; wr_first <= 1'b0;
          end
          BS_RDATA: begin
            if (rise) begin
              bitcnt <= bitcnt + 4'd1;
              if (bitcnt == 4'd7) rd_next <= 1'b1;
            end
            if (fall) begin
              if (bitcnt == 4'd8) begin
                st <= BS_RACK; sda_oe <= 1'b0;
              end else begin
                sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6];
              end
            end
          end
          BS_RACK: begin
            if (rise) mack <= ~sda_s;
            if (fall) begin
              if (mack) begin
                st <= BS_RDATA; bitcnt <= '0; sh <= rd_byte; sda_oe <= ~rd_byte[7];
              end else begin
                st <= BS_IDLE;
              end
            end
          end
          default: st <= BS_IDLE;
        endcase
      end
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BS_IDLE) |-> !sda_oe); // R1
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_next)); // R2
endmodule

// File: rtl/ctl_reg_file.sv
module ctl_reg_file
  import sensor_ctl_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txn_start,
  input  logic       rd_start,
  input  logic       rd_next,
  input  logic       wr_valid,
  input  logic       wr_first,
  input  logic [7:0] wr_byte,
  output logic [7:0] rd_byte,
  output logic       chip_en
);
  localparam int IDXW = $clog2(NREG);

  logic [15:0] regs [NREG];
  logic [7:0]  ptr, hi_byte;
  logic        hi_pend, half, cen;
  logic [15:0] shadow;
  logic        hold;

  assign hold    = regs[HOLD_PTR[IDXW-1:0]][0];
  assign rd_byte = half ? shadow[7:0] : shadow[15:8];
  assign chip_en = cen;

  function automatic logic [15:0] rd_val(input logic [7:0] p);
    if (p == ID_PTR)       return ID_VALUE;
    else if (p == CEN_PTR) return {15'd0, cen};
    else if (p < NREG)     return regs[p[IDXW-1:0]];
    else                   return '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      ptr <= '0; hi_byte <= '0; hi_pend <= 1'b0; half <= 1'b0;
      cen <= 1'b0; shadow <= '0;
    end else begin
      if (txn_start) hi_pend <= 1'b0;
      if (wr_valid) begin
        if (wr_first) begin
          ptr <= wr_byte; hi_pend <= 1'b0;
        end else if (!hi_pend) begin
          hi_byte <= wr_byte; hi_pend <= 1'b1;
        end else begin
          hi_pend <= 1'b0;
          ptr <= ptr + 8'd1;
          if (ptr == HOLD_PTR) regs[HOLD_PTR[IDXW-1:0]] <= {hi_byte, wr_byte};
          else if (!hold) begin
            if (ptr != ID_PTR && ptr < NREG) regs[ptr[IDXW-1:0]] <= {hi_byte, wr_byte};
            if (ptr == CEN_PTR) cen <= wr_byte[0];
          end
        end
      end
      if (rd_start) begin
        shadow <= rd_val(ptr); half <= 1'b0;
      end else if (rd_next) begin
        if (!half) half <= 1'b1;
        else begin
          half <= 1'b0; ptr <= ptr + 8'd1; shadow <= rd_val(ptr + 8'd1);
        end
      end
      if (hold) begin
        for (int i = 1; i < NREG; i++)
          if (i != HOLD_PTR) regs[i] <= '0;
        cen <= 1'b0;
      end
    end
  end

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_first && hi_pend && !rd_next) |=> (ptr == $past(ptr) + 8'd1)); // R3
  AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && ptr == ID_PTR) |=> (shadow == ID_VALUE)); // R5
  AST_HOLD_CEN: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !chip_en); // R6
  AST_READ_DROPS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_start && rd_start) |=> !hi_pend); // R9
endmodule

// File: rtl/sensor_ctl_target.sv
module sensor_ctl_target #(
  parameter int NREG        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  output logic chip_en
);
  logic       scl_s, sda_s;
  logic       txn_start, rd_start, rd_next, wr_valid, wr_first;
  logic [7:0] wr_byte, rd_byte;

  bus_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s)
  );

  bus_bit_engine u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .rd_byte(rd_byte), .sda_oe(sda_oe), .txn_start(txn_start),
    .rd_start(rd_start), .rd_next(rd_next), .wr_valid(wr_valid),
    .wr_first(wr_first), .wr_byte(wr_byte)
  );

  ctl_reg_file #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .rd_start(rd_start),
    .rd_next(rd_next), .wr_valid(wr_valid), .wr_first(wr_first),
    .wr_byte(wr_byte), .rd_byte(rd_byte), .chip_en(chip_en)
  );
endmodule

// File: tb/sensor_ctl_target_tb.sv
module sensor_ctl_target_tb;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, chip_en;
  logic sda_bus;
  int checks = 0, errors = 0;
  logic [15:0] mdl [256];
  logic [15:0] wv [8];
  bit done = 0;

  always #5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  sensor_ctl_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .chip_en(chip_en)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_read(input logic [7:0] p);
    return (p == 8'h00) ? 16'h8431 : mdl[p];
  endfunction

  function automatic void model_write(input logic [7:0] p, input logic [15:0] v);
    if (p == 8'h0D) mdl[p] = v;
    else if (!mdl[8'h0D][0]) begin
      if (p >= 8'h01 && p <= 8'h0F) mdl[p] = v;
      else if (p == 8'hF1) mdl[p] = {15'd0, v[0]};
    end
    if (mdl[8'h0D][0]) begin
      for (int i = 1; i < 16; i++) if (i != 13) mdl[i] = '0;
      mdl[8'hF1] = '0;
    end
  endfunction

  task automatic wq; repeat (Q) @(negedge clk); endtask

  task automatic bit_out(input logic b);
    m_sda = b; wq; m_scl = 1'b1; wq; wq; m_scl = 1'b0; wq;
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; wq; m_scl = 1'b1; wq; b = sda_bus; wq; m_scl = 1'b0; wq;
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wq; m_scl = 1'b1; wq; m_sda = 1'b0; wq; m_scl = 1'b0; wq;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq; m_scl = 1'b1; wq; m_sda = 1'b1; wq;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(x);
    ack = ~x;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin bit_in(x); b[i] = x; end
    bit_out(~ack);
  endtask

  task automatic do_write(input logic [7:0] p, input int n);
    logic ack;
    bus_start;
    send_byte(8'hBA, ack); chk(ack, "R1 write address ack", {15'd0, ack}, 16'd1);
    send_byte(p, ack);
    for (int i = 0; i < n; i++) begin
      send_byte(wv[i][15:8], ack);
      send_byte(wv[i][7:0], ack);
      model_write(p + 8'(i), wv[i]);
    end
    bus_stop;
  endtask

  task automatic do_read(input logic [7:0] p, input int n, input string req);
    logic ack;
    logic [7:0] hi, lo;
    bus_start;
    send_byte(8'hBA, ack);
    send_byte(p, ack);
    bus_start;
    send_byte(8'hBB, ack); chk(ack, "R4 read address ack", {15'd0, ack}, 16'd1);
    for (int i = 0; i < n; i++) begin
      recv_byte(1'b1, hi);
      recv_byte(i != n - 1, lo);
      chk({hi, lo} == model_read(p + 8'(i)), req, {hi, lo}, model_read(p + 8'(i)));
    end
    bus_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'd0, 16'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b, hi, lo;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mdl[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(sda_oe == 1'b0, "R10 sda_oe idle after reset", {15'd0, sda_oe}, 16'd0);
    chk(chip_en == 1'b0, "R7 chip_en after reset", {15'd0, chip_en}, 16'd0);

    // R5 R8 identification word and reset contents
    do_read(8'h00, 3, "R5 id and reset values");
    wv[0] = 16'h1234; do_write(8'h00, 1);
    do_read(8'h00, 1, "R5 id is read-only");

    // R1 foreign address: no ack, following bytes ignored
    bus_start;
    send_byte(8'h44, ack); chk(!ack, "R1 foreign address not acked", {15'd0, ack}, 16'd0);
    send_byte(8'h03, ack); send_byte(8'h12, ack); send_byte(8'h34, ack);
    chk(!ack, "R1 ignored data not acked", {15'd0, ack}, 16'd0);
    bus_stop;
    do_read(8'h03, 1, "R1 ignored transaction left register");

    // R2 R3 burst window write and burst read
    wv[0] = 16'h000C; wv[1] = 16'h0014; wv[2] = 16'h03FF; wv[3] = 16'h04FF;
    do_write(8'h01, 4);
    do_read(8'h01, 4, "R3 burst read after R2 burst write");

    // R7 chip enable
    wv[0] = 16'hFFFF; do_write(8'hF1, 1);
    chk(chip_en == 1'b1, "R7 chip_en set", {15'd0, chip_en}, 16'd1);
    do_read(8'hF1, 1, "R7 chip enable readback");

    // R8 unmapped
    wv[0] = 16'hABCD; do_write(8'h40, 1);
    do_read(8'h40, 1, "R8 unmapped reads zero");

    // R3 pointer wrap
    wv[0] = 16'h5555; wv[1] = 16'h6666; do_write(8'hFF, 2);
    do_read(8'hFF, 3, "R3 pointer wraps");

    // R9 read after a lone high byte
    bus_start;
    send_byte(8'hBA, ack); send_byte(8'h02, ack); send_byte(8'h77, ack);
    bus_start;
    send_byte(8'hBB, ack);
    recv_byte(1'b1, hi); recv_byte(1'b0, lo);
    chk({hi, lo} == model_read(8'h02), "R9 latched pair after lone high byte", {hi, lo}, model_read(8'h02));
    bus_stop;
    do_read(8'h02, 1, "R9 register unchanged");

    // R6 hold in reset
    wv[0] = 16'h0001; do_write(8'h0D, 1);
    chk(chip_en == 1'b0, "R6 hold clears chip_en", {15'd0, chip_en}, 16'd0);
    do_read(8'h01, 4, "R6 held registers read zero");
    wv[0] = 16'h0005; wv[1] = 16'h0001; do_write(8'h01, 1); b = 8'hF1;
    do_write(b, 1);
    chk(chip_en == 1'b0, "R6 writes ignored while held", {15'd0, chip_en}, 16'd0);
    do_read(8'h01, 1, "R6 write ignored while held");
    wv[0] = 16'h0000; do_write(8'h0D, 1);
    wv[0] = 16'h0005; do_write(8'h01, 1);
    do_read(8'h01, 1, "R6 released file writable");

    // random bursts
    for (int it = 0; it < 18; it++) begin
      int sel, n;
      logic [7:0] p;
      sel = $urandom_range(0, 17);
      p = (sel == 16) ? 8'hF1 : (sel == 17) ? 8'hFE : 8'(sel);
      n = $urandom_range(1, 3);
      for (int k = 0; k < n; k++) begin
        wv[k] = 16'($urandom);
        if (p + 8'(k) == 8'h0D) wv[k][0] = ($urandom_range(0, 3) == 0);
      end
      do_write(p, n);
      chk(chip_en == mdl[8'hF1][0], "R7 chip_en after random write", {15'd0, chip_en}, {15'd0, mdl[8'hF1][0]});
      do_read(p, n, "R2 R4 random burst readback");
    end
    chk(sda_oe == 1'b0, "R10 sda released at end", {15'd0, sda_oe}, 16'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule